// File: doc/BRIEF.md
# Parallel LCD Register Bus Master

This block turns register write and register read commands into strobe sequences on an 18-line parallel bus. The bus follows the 8080 style and connects to a display controller. Commands arrive on a valid/ready port. Each command carries a read/write flag, a 16-bit register index and a 16-bit value. On the bus, each 16-bit word is split into its two bytes, and a low gap line sits under each byte.

A write takes two bus cycles:
- an index cycle, with register-select low;
- a value cycle, with register-select high.

Each cycle pulls the write strobe low for a programmable setup count. It then holds the word for a programmable hold count after the strobe rises.

A read first latches the index with a write strobe. It then releases the bus and drives the enable line through a fixed choreography. The bus is sampled while enable is low. Every command ends with a one-cycle response pulse, which returns the read word or reports a timeout.

Top module: `lcd_regbus_master`

## Requirements
- R1: After reset and whenever idle, chip select, register-select, write strobe and enable are high, the bus is driven (output enable high) with all lines zero, `cmd_ready` is high and `rsp_valid` is low.
- R2: A driven 16-bit word `w` appears as lines[8:1] = w[7:0] and lines[17:10] = w[15:8], with lines 0 and 9 low.
- R3: A write is an index cycle (register-select low, index on the bus), followed by a value cycle (register-select high, value on the bus). In each cycle the write strobe is low for its setup count and then high for its hold count. Chip select stays low across both cycles and is high again in the response cycle.
- R4: Each timing input (`cfg_idx_setup`, `cfg_idx_hold`, `cfg_val_setup`, `cfg_val_hold`, `cfg_rd_phase`) is used as given when nonzero. A zero selects the default: 2, 2, 1, 2 and 1 cycles respectively.
- R5: A read runs 12 phases of `cfg_rd_phase` cycles each, numbered 0 to 11.
  - Register-select is low in phases 0 to 6.
  - Chip select is low in phases 1 to 10.
  - The write strobe is low in phases 2 and 3.
  - Enable is low in phases 6, 7 and 9.
  - The index is on the bus in phases 3 and 4.
- R6: During a read the bus is released (output enable low, `lcd_d_out` zero) from phase 5 to phase 11. Enable is never low while the master drives.
- R7: Read data is taken from the bus in the last cycle of phase 9, using the mapping of R2 in reverse. It is returned on `rsp_data` with the response pulse. The levels on lines 0 and 9 are ignored.
- R8: `cmd_ready` is low from the accepting edge until the response cycle. A command offered while busy is not accepted and does not alter the transfer in progress.
- R9: Every command yields exactly one `rsp_valid` pulse of one cycle, one clock after its last bus cycle. A completed write returns `rsp_data` = 0 and `rsp_err` = 0.
- R10: If a transfer has not completed within its first `TIMEOUT_CYC` busy cycles, it is abandoned. The bus returns to the idle state of R1, and `rsp_valid` pulses with `rsp_err` = 1 and `rsp_data` = 0. A transfer whose final cycle is exactly its `TIMEOUT_CYC`-th busy cycle completes normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high together with `cmd_valid` |
| cmd_read | input | 1 | 1 = register read, 0 = register write |
| cmd_index | input | 16 | Register index |
| cmd_value | input | 16 | Write value (ignored for reads) |
| cfg_idx_setup | input | CW | Index-cycle write-strobe low count, 0 = default |
| cfg_idx_hold | input | CW | Index-cycle hold count after strobe rise, 0 = default |
| cfg_val_setup | input | CW | Value-cycle write-strobe low count, 0 = default |
| cfg_val_hold | input | CW | Value-cycle hold count, 0 = default |
| cfg_rd_phase | input | CW | Cycles per read phase, 0 = default |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_data | output | 16 | Read word (zero for writes and errors) |
| rsp_err | output | 1 | Timeout indication, valid with `rsp_valid` |
| lcd_cs_n | output | 1 | Chip select, active low |
| lcd_rs | output | 1 | Register-select: low = index, high = value |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_en | output | 1 | Read enable line, idle high |
| lcd_d_out | output | 18 | Bus value driven by the master |
| lcd_d_oe | output | 1 | Bus output enable |
| lcd_d_in | input | 18 | Bus value seen at the pads |

## Verification
The completion of a transfer and the expiry of the timeout window can fall in the same cycle. This happens when a transfer's final cycle is exactly its `TIMEOUT_CYC`-th busy cycle. The bench provokes this twice: with a read of twelve 85-cycle phases, and with a write whose four counts are all 255. Both total exactly 1020 cycles. It then expects a clean response with the read word and no error flag. A read of 86-cycle phases crosses the limit, and the bench expects the error response exactly 1020 busy cycles after acceptance. The bench also holds a conflicting command on the port for a whole transfer, which checks that the response cycle and the next acceptance do not interfere.

// File: rtl/lcd_regbus_master.sv
module lcd_regbus_master #(
  parameter int CW             = 8,
  parameter int TIMEOUT_CYC    = 1020,
  parameter int DEF_IDX_SETUP  = 2,
  parameter int DEF_IDX_HOLD   = 2,
  parameter int DEF_VAL_SETUP  = 1,
  parameter int DEF_VAL_HOLD   = 2,
  parameter int DEF_RD_PHASE   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_read,
  input  logic [15:0]   cmd_index,
  input  logic [15:0]   cmd_value,
  input  logic [CW-1:0] cfg_idx_setup,
  input  logic [CW-1:0] cfg_idx_hold,
  input  logic [CW-1:0] cfg_val_setup,
  input  logic [CW-1:0] cfg_val_hold,
  input  logic [CW-1:0] cfg_rd_phase,
  output logic          rsp_valid,
  output logic [15:0]   rsp_data,
  output logic          rsp_err,
  output logic          lcd_cs_n,
  output logic          lcd_rs,
  output logic          lcd_wr_n,
  output logic          lcd_en,
  output logic [17:0]   lcd_d_out,
  output logic          lcd_d_oe,
  input  logic [17:0]   lcd_d_in
);

  localparam int TW        = $clog2(TIMEOUT_CYC);
  localparam int LAST_STEP = 11;
  localparam int SAMP_STEP = 9;

  typedef enum logic [2:0] {S_IDLE, S_ISET, S_IHLD, S_VSET, S_VHLD, S_READ} state_t;

  state_t        state;
  logic [CW-1:0] pcnt, plen;
  logic [3:0]    step;
  logic [TW-1:0] tcnt;
  logic          is_rd;
  logic [15:0]   idx_q, val_q, rd_buf;

  function automatic logic [17:0] to_bus(input logic [15:0] w);
    return {w[15:8], 1'b0, w[7:0], 1'b0};
  endfunction

  function automatic logic [CW-1:0] pick(input logic [CW-1:0] c, input int d);
    return (c == '0) ? CW'(d) : c;
  endfunction

  wire gap_unused = lcd_d_in[0] ^ lcd_d_in[9];

  always_comb begin
    case (state)
      S_ISET:  plen = pick(cfg_idx_setup, DEF_IDX_SETUP);
      S_IHLD:  plen = pick(cfg_idx_hold,  DEF_IDX_HOLD);
      S_VSET:  plen = pick(cfg_val_setup, DEF_VAL_SETUP);
      S_VHLD:  plen = pick(cfg_val_hold,  DEF_VAL_HOLD);
      default: plen = pick(cfg_rd_phase,  DEF_RD_PHASE);
    endcase
  end

  wire phase_end = (pcnt == plen - CW'(1));
  wire finishing = phase_end &&
                   (state == S_VHLD || (state == S_READ && step == 4'(LAST_STEP)));
  wire expired   = (tcnt == TW'(TIMEOUT_CYC - 1));

  assign cmd_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      pcnt      <= '0;
      step      <= '0;
      tcnt      <= '0;
      is_rd     <= 1'b0;
      idx_q     <= '0;
      val_q     <= '0;
      rd_buf    <= '0;
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      if (state == S_IDLE) begin
        if (cmd_valid) begin
          is_rd <= cmd_read;
          idx_q <= cmd_index;
          val_q <= cmd_value;
          state <= cmd_read ? S_READ : S_ISET;
          pcnt  <= '0;
          step  <= '0;
          tcnt  <= '0;
        end
      end else begin
        tcnt <= tcnt + TW'(1);
        if (state == S_READ && step == 4'(SAMP_STEP) && phase_end)
          rd_buf <= {lcd_d_in[17:10], lcd_d_in[8:1]};
        if (finishing) begin
          state     <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_data  <= is_rd ? rd_buf : 16'h0000;
        end else if (expired) begin
          state     <= S_IDLE;
          rsp_valid <= 1'b1;
          rsp_err   <= 1'b1;
          rsp_data  <= 16'h0000;
        end else if (phase_end) begin
          pcnt <= '0;
          case (state)
            S_ISET:  state <= S_IHLD;
            S_IHLD:  state <= S_VSET;
            S_VSET:  state <= S_VHLD;
            default: step  <= step + 4'd1;
          endcase
        end else begin
          pcnt <= pcnt + CW'(1);
        end
      end
    end
  end

  always_comb begin
    lcd_cs_n  = 1'b1;
    lcd_rs    = 1'b1;
    lcd_wr_n  = 1'b1;
    lcd_en    = 1'b1;
    lcd_d_oe  = 1'b1;
    lcd_d_out = '0;
    case (state)
      S_ISET: begin lcd_cs_n = 1'b0; lcd_rs = 1'b0; lcd_wr_n = 1'b0; lcd_d_out = to_bus(idx_q); end
      S_IHLD: begin lcd_cs_n = 1'b0; lcd_rs = 1'b0; lcd_d_out = to_bus(idx_q); end
      S_VSET: begin lcd_cs_n = 1'b0; lcd_wr_n = 1'b0; lcd_d_out = to_bus(val_q); end
      S_VHLD: begin lcd_cs_n = 1'b0; lcd_d_out = to_bus(val_q); end
      S_READ: begin
        lcd_rs    = (step >= 4'd7);
        lcd_cs_n  = (step == 4'd0) || (step == 4'd11);
        lcd_wr_n  = !(step == 4'd2 || step == 4'd3);
        lcd_en    = !(step == 4'd6 || step == 4'd7 || step == 4'd9);
        lcd_d_oe  = (step <= 4'd4);
        lcd_d_out = (step == 4'd3 || step == 4'd4) ? to_bus(idx_q) : 18'h0;
      end
      default: ;
    endcase
  end

  // R6
  en_while_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_en |-> !lcd_d_oe);

  // R3
  wr_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> (!lcd_cs_n && lcd_d_oe));

  // R2
  gap_lines_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_d_oe |-> (!lcd_d_out[0] && !lcd_d_out[9]));

  // R9
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8
  ready_means_idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (lcd_cs_n && lcd_wr_n && lcd_en && lcd_rs && lcd_d_oe && lcd_d_out == 18'h0));

  // R10
  err_payload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_valid && rsp_data == 16'h0000));

  // R9
  rsp_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rsp_valid) |-> $past(!cmd_ready));

endmodule

// File: tb/lcd_regbus_master_test.sv
module lcd_regbus_master_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_read = 1'b0;
  logic [15:0] cmd_index = '0, cmd_value = '0;
  logic [7:0]  c_is = '0, c_ih = '0, c_vs = '0, c_vh = '0, c_rp = '0;
  logic        cmd_ready, rsp_valid, rsp_err;
  logic [15:0] rsp_data;
  logic        lcd_cs_n, lcd_rs, lcd_wr_n, lcd_en, lcd_d_oe;
  logic [17:0] lcd_d_out, lcd_d_in;
  logic [15:0] disp_word = '0;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  function automatic logic [17:0] mapw(input logic [15:0] w);
    return {w[15:8], 1'b0, w[7:0], 1'b0};
  endfunction

  assign lcd_d_in = lcd_d_oe ? 18'h0 : (mapw(disp_word) | 18'h00201);

  lcd_regbus_master uut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_read(cmd_read), .cmd_index(cmd_index), .cmd_value(cmd_value),
    .cfg_idx_setup(c_is), .cfg_idx_hold(c_ih), .cfg_val_setup(c_vs),
    .cfg_val_hold(c_vh), .cfg_rd_phase(c_rp),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .lcd_cs_n(lcd_cs_n), .lcd_rs(lcd_rs), .lcd_wr_n(lcd_wr_n), .lcd_en(lcd_en),
    .lcd_d_out(lcd_d_out), .lcd_d_oe(lcd_d_oe), .lcd_d_in(lcd_d_in)
  );

  wire [23:0] obs = {cmd_ready, lcd_cs_n, lcd_rs, lcd_wr_n, lcd_en, lcd_d_oe, lcd_d_out};
  localparam logic [23:0] IDLE_T = {1'b1, 5'b11111, 18'h0};

  task automatic check(input bit ok, input string what, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic int eff(input logic [7:0] c, input int d);
    return (c == 0) ? d : int'(c);
  endfunction

  function automatic logic [23:0] wr_exp(input int p, input logic [15:0] i, input logic [15:0] v);
    return {1'b0, 1'b0, (p >= 2), p[0], 1'b1, 1'b1, (p < 2) ? mapw(i) : mapw(v)};
  endfunction

  function automatic logic [23:0] rd_exp(input int s, input logic [15:0] i);
    logic csn, rs, wrn, en, oe;
    rs  = (s >= 7);
    csn = (s == 0 || s == 11);
    wrn = !(s == 2 || s == 3);
    en  = !(s == 6 || s == 7 || s == 9);
    oe  = (s <= 4);
    return {1'b0, csn, rs, wrn, en, oe, (s == 3 || s == 4) ? mapw(i) : 18'h0};
  endfunction

  task automatic run(input logic rd, input logic [15:0] idx, input logic [15:0] val,
                     input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                     input logic [7:0] d, input logic [7:0] r, input bit noise);
    int bad = 0;
    logic [23:0] fa = '0, fe = '0, e;
    int len;
    @(negedge clk);
    cmd_read = rd; cmd_index = idx; cmd_value = val; disp_word = val;
    c_is = a; c_ih = b; c_vs = c; c_vh = d; c_rp = r;
    cmd_valid = 1'b1;
    @(posedge clk); #1;
    if (noise) begin
      cmd_read = ~rd; cmd_index = ~idx; cmd_value = ~val;
    end else cmd_valid = 1'b0;
    for (int p = 0; p < (rd ? 12 : 4); p++) begin
      if (rd) len = eff(r, 1);
      else len = (p == 0) ? eff(a, 2) : (p == 1) ? eff(b, 2) : (p == 2) ? eff(c, 1) : eff(d, 2);
      e = rd ? rd_exp(p, idx) : wr_exp(p, idx, val);
      for (int k = 0; k < len; k++) begin
        @(negedge clk);
        if (obs !== e) begin
          if (bad == 0) begin fa = obs; fe = e; end
          bad++;
        end
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0;
    if (rd) check(bad == 0, "R2 R5 R6 R8 read bus trace", fa, fe);
    else    check(bad == 0, "R2 R3 R4 R8 write bus trace", fa, fe);
    check(rsp_valid === 1'b1 && rsp_err === 1'b0 && rsp_data === (rd ? val : 16'h0),
          rd ? "R7 R9 read response" : "R9 write response",
          {7'h0, rsp_valid, rsp_data}, {7'h0, 1'b1, rd ? val : 16'h0});
    check(obs === IDLE_T, "R1 R3 idle after response", obs, IDLE_T);
    if (noise) begin
      @(negedge clk);
      check(obs === IDLE_T && rsp_valid === 1'b0, "R8 busy command not taken", obs, IDLE_T);
    end
  endtask

  localparam int NV = 8;
  localparam logic [52:0] VEC [NV] = '{
    {1'b0, 16'h00e5, 16'h78f0, 20'h00000},
    {1'b0, 16'hffff, 16'hffff, 20'h11110},
    {1'b0, 16'h1234, 16'ha700, 20'h34560},
    {1'b1, 16'h0000, 16'h9325, 20'h00000},
    {1'b1, 16'hffff, 16'h00ff, 20'h00003},
    {1'b1, 16'h0022, 16'hff00, 20'h77772},
    {1'b0, 16'h0007, 16'h0173, 20'hf1f10},
    {1'b1, 16'h5a5a, 16'ha5a5, 20'h00004}
  };

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, R1..R10 incomplete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    #1;
    check(lcd_cs_n === 1'b1 && lcd_wr_n === 1'b1 && lcd_en === 1'b1 && rsp_valid === 1'b0,
          "R1 outputs in reset", obs, IDLE_T);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(obs === IDLE_T && rsp_valid === 1'b0, "R1 idle after reset", obs, IDLE_T);

    for (int v = 0; v < NV; v++)
      run(VEC[v][52], VEC[v][51:36], VEC[v][35:20], {4'h0, VEC[v][19:16]},
          {4'h0, VEC[v][15:12]}, {4'h0, VEC[v][11:8]}, {4'h0, VEC[v][7:4]},
          {4'h0, VEC[v][3:0]}, 1'b0);

    // R8: conflicting command held during a write and a read
    run(1'b0, 16'h0003, 16'h1030, 8'd2, 8'd3, 8'd2, 8'd1, 8'd0, 1'b1);
    run(1'b1, 16'h0010, 16'h4321, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2, 1'b1);

    // R10: completion lands on the last allowed cycle
    run(1'b1, 16'h00aa, 16'h1357, 8'd0, 8'd0, 8'd0, 8'd0, 8'd85, 1'b0);
    run(1'b0, 16'h00bb, 16'h2468, 8'd255, 8'd255, 8'd255, 8'd255, 8'd0, 1'b0);

    // R10: one cycle per phase too many
    @(negedge clk);
    cmd_read = 1'b1; cmd_index = 16'h0042; disp_word = 16'hbeef; c_rp = 8'd86;
    cmd_valid = 1'b1;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (rsp_valid !== 1'b1 && n < 2000);
    check(n == 1021, "R10 timeout response cycle", 24'(n), 24'd1021);
    check(rsp_err === 1'b1 && rsp_data === 16'h0, "R10 timeout error payload",
          {7'h0, rsp_err, rsp_data}, {7'h0, 1'b1, 16'h0});
    check(obs === IDLE_T, "R10 bus idle after abort", obs, IDLE_T);

    // R9: normal traffic still clean after an abort
    run(1'b1, 16'h0001, 16'h0100, 8'd0, 8'd0, 8'd0, 8'd0, 8'd1, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule